// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block turns a bank of already synchronized GPIO inputs into per-pin interrupt status and a single combined interrupt line. Each pin is configured with five one-bit settings: detection on or off, edge or level sensing, active sense (high/rising or low/falling), output masking, and an optional input filter. The filter advances only on a slow enable pulse `db_tick`.

The bus side writes the settings through one narrow write port. A selector code picks which setting vector is loaded with `wr_data`. The same port carries a write-one-to-clear acknowledge that drops latched edge events. Software sees two status vectors. `raw_status` holds every detected event whether or not it is masked. `masked_status` holds only the events that may reach the interrupt line. `irq_out` is a registered OR of the masked vector.

Top module: `gpio_irq_unit`

## Requirements
- R1: After synchronous reset, every setting vector is zero, `raw_status` and `masked_status` are zero, and `irq_out` is low.
- R2: A cycle with `wr_en` high loads `wr_data`, with bit n belonging to pin n, into the vector chosen by `wr_sel`. The codes are 0 enable, 1 mask, 2 sense type (1 = edge, 0 = level), 3 polarity (1 = rising/high, 0 = falling/low), 4 filter enable, and 5 acknowledge. The new value is used by detection from the following clock edge.
- R3: An enabled edge-type pin sets its `raw_status` bit on the clock edge after its detected input makes the transition selected by polarity. The bit stays set while the input holds still.
- R4: For an enabled level-type pin, `raw_status` is the comparison of the detected input with the polarity bit, delayed by one clock. An acknowledge write does not clear it.
- R5: A pin whose enable bit is 0 has its `raw_status` bit cleared on the next edge. It detects nothing while disabled, including bits that were already latched.
- R6: An acknowledge write clears the latched edge bit of each pin whose `wr_data` bit is 1 and leaves the other pins alone. All ones clears every latched edge.
- R7: If an edge event and an acknowledge for the same pin arrive in the same cycle, the event wins and the bit stays set.
- R8: `masked_status` equals `raw_status` with masked pins forced to 0. Masking does not stop `raw_status` from recording events.
- R9: `irq_out` is the OR of `masked_status`, registered one cycle.
- R10: With the filter enabled, a change of the pin is passed to detection only after the pin has differed from the accepted value at `DB_TICKS` consecutive `db_tick` cycles. Between ticks the accepted value does not move. With the filter disabled, detection sees the live pin.
- R11: A pulse that reverts before `DB_TICKS` consecutive ticks is discarded and raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NPINS | Synchronized pin levels |
| db_tick | input | 1 | Slow enable that advances the input filter |
| wr_en | input | 1 | Setting write strobe |
| wr_sel | input | 3 | Setting selector code |
| wr_data | input | NPINS | Per-pin write data |
| raw_status | output | NPINS | Detected events before masking |
| masked_status | output | NPINS | Detected events after masking |
| irq_out | output | 1 | Combined interrupt line |

## Verification
The bench builds the unit with `NPINS = 8` and `DB_TICKS = 2`. Eight pins are enough to run all four sense combinations side by side, so interference between pins is visible in every status snapshot. With a filter length of two, the bench drives `db_tick` by hand and can show three cases: a one-tick glitch being dropped, a real change held back after the first tick, and that change accepted on the second tick.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef enum logic [2:0] {
        SEL_ENABLE   = 3'd0,
        SEL_MASK     = 3'd1,
        SEL_TYPE     = 3'd2,
        SEL_POL      = 3'd3,
        SEL_DEBOUNCE = 3'd4,
        SEL_ACK      = 3'd5
    } cfg_sel_e;

    typedef struct packed {
        logic en;
        logic msk;
        logic is_edge;
        logic pol;
        logic deb;
    } pin_cfg_t;

    function automatic logic edge_hit(input logic cur, input logic prev, input logic pol);
        return pol ? (cur & ~prev) : (~cur & prev);
    endfunction

    function automatic logic level_hit(input logic cur, input logic pol);
        return cur == pol;
    endfunction

endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  cfg_sel_e                    wr_sel,
    input  logic [NPINS-1:0]            wr_data,
    output pin_cfg_t [NPINS-1:0]        cfg,
    output logic [NPINS-1:0]            ack
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NPINS; i++) begin
                case (wr_sel)
                    SEL_ENABLE:   cfg[i].en      <= wr_data[i];
                    SEL_MASK:     cfg[i].msk     <= wr_data[i];
                    SEL_TYPE:     cfg[i].is_edge <= wr_data[i];
                    SEL_POL:      cfg[i].pol     <= wr_data[i];
                    SEL_DEBOUNCE: cfg[i].deb     <= wr_data[i];
                    default:      ;
                endcase
            end
        end
    end

    assign ack = (wr_en && wr_sel == SEL_ACK) ? wr_data : '0;

    assert_ack_only_on_write_R6: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> ack == '0);

endmodule

// File: rtl/gpio_irq_debounce.sv
module gpio_irq_debounce #(
    parameter int NPINS    = 32,
    parameter int DB_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [NPINS-1:0] pin,
    input  logic [NPINS-1:0] deb_en,
    output logic [NPINS-1:0] det
);

    localparam int CW = $clog2(DB_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(DB_TICKS - 1);

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        logic          filt;
        logic [CW-1:0] cnt;

        always_ff @(posedge clk) begin
            if (rst) begin
                filt <= 1'b0;
                cnt  <= '0;
            end else if (!deb_en[g]) begin
                filt <= pin[g];
                cnt  <= '0;
            end else if (tick) begin
                if (pin[g] != filt) begin
                    if (cnt == LAST) begin
                        filt <= pin[g];
                        cnt  <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end else begin
                    cnt <= '0;
                end
            end
        end

        assign det[g] = deb_en[g] ? filt : pin[g];

        assert_hold_between_ticks_R10: assert property (@(posedge clk) disable iff (rst)
            (deb_en[g] && !tick) |=> $stable(filt));

        assert_no_change_on_match_R11: assert property (@(posedge clk) disable iff (rst)
            (deb_en[g] && pin[g] == filt) |=> $stable(filt));
    end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NPINS-1:0]     det,
    input  pin_cfg_t [NPINS-1:0] cfg,
    input  logic [NPINS-1:0]     ack,
    output logic [NPINS-1:0]     raw
);

    logic [NPINS-1:0] prev;
    logic [NPINS-1:0] edge_now;

    always_comb begin
        for (int i = 0; i < NPINS; i++) begin
            edge_now[i] = edge_hit(det[i], prev[i], cfg[i].pol);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw  <= '0;
            prev <= '0;
        end else begin
            prev <= det;
            for (int i = 0; i < NPINS; i++) begin
                if (!cfg[i].en)
                    raw[i] <= 1'b0;
                else if (!cfg[i].is_edge)
                    raw[i] <= level_hit(det[i], cfg[i].pol);
                else
                    raw[i] <= edge_now[i] | (raw[i] & ~ack[i]);
            end
        end
    end

    for (genvar g = 0; g < NPINS; g++) begin : g_chk
        assert_off_clears_R5: assert property (@(posedge clk) disable iff (rst)
            !cfg[g].en |=> !raw[g]);

        assert_edge_latched_R3: assert property (@(posedge clk) disable iff (rst)
            (cfg[g].en && cfg[g].is_edge && raw[g] && !ack[g]) |=> raw[g]);

        assert_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
            (cfg[g].en && cfg[g].is_edge && ack[g] && !edge_now[g]) |=> !raw[g]);

        assert_event_beats_ack_R7: assert property (@(posedge clk) disable iff (rst)
            (cfg[g].en && cfg[g].is_edge && edge_now[g]) |=> raw[g]);

        assert_level_follows_R4: assert property (@(posedge clk) disable iff (rst)
            (cfg[g].en && !cfg[g].is_edge && det[g] == cfg[g].pol) |=> raw[g]);
    end

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int NPINS    = 32,
    parameter int DB_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pin_in,
    input  logic             db_tick,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [NPINS-1:0] wr_data,
    output logic [NPINS-1:0] raw_status,
    output logic [NPINS-1:0] masked_status,
    output logic             irq_out
);

    pin_cfg_t [NPINS-1:0] cfg;
    logic [NPINS-1:0]     ack;
    logic [NPINS-1:0]     det;
    logic [NPINS-1:0]     mask_v;
    logic [NPINS-1:0]     deb_v;

    gpio_irq_cfg #(.NPINS(NPINS)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (cfg_sel_e'(wr_sel)),
        .wr_data (wr_data),
        .cfg     (cfg),
        .ack     (ack)
    );

    always_comb begin
        for (int i = 0; i < NPINS; i++) begin
            mask_v[i] = cfg[i].msk;
            deb_v[i]  = cfg[i].deb;
        end
    end

    gpio_irq_debounce #(.NPINS(NPINS), .DB_TICKS(DB_TICKS)) u_deb (
        .clk    (clk),
        .rst    (rst),
        .tick   (db_tick),
        .pin    (pin_in),
        .deb_en (deb_v),
        .det    (det)
    );

    gpio_irq_detect #(.NPINS(NPINS)) u_det (
        .clk (clk),
        .rst (rst),
        .det (det),
        .cfg (cfg),
        .ack (ack),
        .raw (raw_status)
    );

    assign masked_status = raw_status & ~mask_v;

    always_ff @(posedge clk) begin
        if (rst) irq_out <= 1'b0;
        else     irq_out <= |masked_status;
    end

    assert_irq_rises_R9: assert property (@(posedge clk) disable iff (rst)
        (|masked_status) |=> irq_out);

    assert_irq_falls_R9: assert property (@(posedge clk) disable iff (rst)
        !(|masked_status) |=> !irq_out);

    assert_mask_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        (raw_status & mask_v) != '0 |-> (masked_status & mask_v) == '0);

endmodule

// File: tb/gpio_irq_unit_test.sv
module gpio_irq_unit_test;

    localparam int  NP      = 8;
    localparam time CLK_PER = 10ns;

    localparam logic [2:0] S_EN = 3'd0, S_MSK = 3'd1, S_TYP = 3'd2,
                           S_POL = 3'd3, S_DEB = 3'd4, S_ACK = 3'd5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pin_in = 8'hCC;
    logic          db_tick = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_sel = 3'd0;
    logic [NP-1:0] wr_data = '0;
    logic [NP-1:0] raw_status, masked_status;
    logic          irq_out;

    typedef struct {
        string         req;
        logic [NP-1:0] raw;
        logic [NP-1:0] msk;
        logic          irq;
        bit            chk_irq;
    } exp_t;

    exp_t q[$];
    int   n_cmp  = 0;
    int   n_bad  = 0;
    bit   done   = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    gpio_irq_unit #(.NPINS(NP), .DB_TICKS(2)) uut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .db_tick(db_tick),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .raw_status(raw_status), .masked_status(masked_status), .irq_out(irq_out)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [NP-1:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic tick();
        db_tick = 1'b1;
        @(negedge clk);
        db_tick = 1'b0;
    endtask

    task automatic expect_st(input string req, input logic [NP-1:0] r,
                             input logic [NP-1:0] m, input logic i, input bit ci);
        exp_t e;
        #1;
        e.req = req; e.raw = r; e.msk = m; e.irq = i; e.chk_irq = ci;
        q.push_back(e);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_cmp++;
                if (raw_status !== e.raw || masked_status !== e.msk ||
                    (e.chk_irq && irq_out !== e.irq)) begin
                    n_bad++;
                    $display("FAIL %s: raw=%h masked=%h irq=%b expected raw=%h masked=%h irq=%b",
                             e.req, raw_status, masked_status, irq_out, e.raw, e.msk, e.irq);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : driver
        step(3);
        rst = 1'b0;
        // R1: reset state
        expect_st("R1", 8'h00, 8'h00, 1'b0, 1);
        step(1);
        // R2: pins 0-3 edge, 4-7 level; polarity rising/high on 0,1,4,5
        wr(S_TYP, 8'h0F);
        wr(S_POL, 8'h33);
        wr(S_EN, 8'hFF);
        step(1);
        expect_st("R2", 8'h00, 8'h00, 1'b0, 1);
        // R3: rising edge on pin 0
        pin_in = 8'hCD; step(1);
        expect_st("R3", 8'h01, 8'h01, 1'b0, 1);
        step(1);
        expect_st("R9", 8'h01, 8'h01, 1'b1, 1);
        // R3: falling edge on pin 2
        pin_in = 8'hC9; step(1);
        expect_st("R3", 8'h05, 8'h05, 1'b1, 1);
        // R6: clear pin 0 only
        wr(S_ACK, 8'h01);
        expect_st("R6", 8'h04, 8'h04, 1'b1, 1);
        // R4: level-high pin 4, not cleared by ack
        pin_in = 8'hD9; step(1);
        expect_st("R4", 8'h14, 8'h14, 1'b1, 1);
        wr(S_ACK, 8'h10);
        expect_st("R4", 8'h14, 8'h14, 1'b1, 1);
        wr(S_ACK, 8'hFF);
        expect_st("R6", 8'h10, 8'h10, 1'b1, 1);
        pin_in = 8'hC9; step(1);
        expect_st("R4", 8'h00, 8'h00, 1'b1, 1);
        step(1);
        expect_st("R9", 8'h00, 8'h00, 1'b0, 1);
        // R4: level-low pin 7
        pin_in = 8'h49; step(1);
        expect_st("R4", 8'h80, 8'h80, 1'b1, 0);
        pin_in = 8'hC9; step(1);
        expect_st("R4", 8'h00, 8'h00, 1'b1, 0);
        step(1);
        // R8: mask pin 0, detection continues
        wr(S_MSK, 8'h01);
        pin_in = 8'hC8; step(1);
        pin_in = 8'hC9; step(1);
        expect_st("R8", 8'h01, 8'h00, 1'b0, 1);
        step(1);
        expect_st("R8", 8'h01, 8'h00, 1'b0, 1);
        wr(S_MSK, 8'h00);
        expect_st("R8", 8'h01, 8'h01, 1'b0, 1);
        step(1);
        expect_st("R9", 8'h01, 8'h01, 1'b1, 1);
        // R7: edge and ack in the same cycle
        pin_in = 8'hC8; step(1);
        wr(S_ACK, 8'hFF);
        expect_st("R6", 8'h00, 8'h00, 1'b1, 0);
        pin_in = 8'hC9;
        wr(S_ACK, 8'h01);
        expect_st("R7", 8'h01, 8'h01, 1'b0, 0);
        // R5: disabling pin 0 drops its latched bit and blocks detection
        wr(S_EN, 8'hFE);
        step(1);
        expect_st("R5", 8'h00, 8'h00, 1'b1, 0);
        pin_in = 8'hC8; step(1);
        pin_in = 8'hC9; step(1);
        expect_st("R5", 8'h00, 8'h00, 1'b0, 1);
        wr(S_EN, 8'hFF);
        step(1);
        // R10/R11: filter on pin 0
        wr(S_DEB, 8'h01);
        pin_in = 8'hC8;
        tick(); tick();
        step(2);
        expect_st("R10", 8'h00, 8'h00, 1'b0, 1);
        pin_in = 8'hC9; tick();
        pin_in = 8'hC8; tick(); tick();
        step(2);
        expect_st("R11", 8'h00, 8'h00, 1'b0, 1);
        pin_in = 8'hC9; tick();
        step(2);
        expect_st("R10", 8'h00, 8'h00, 1'b0, 1);
        tick();
        step(1);
        expect_st("R10", 8'h01, 8'h01, 1'b0, 1);
        step(1);
        expect_st("R9", 8'h01, 8'h01, 1'b1, 1);
        step(3);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule